// File: doc/BRIEF.md
# Multi-frame window transmit segmenter

This block sits in front of a serial infrared transmitter. It accepts one transfer block of bytes over a valid/ready stream and divides it into a window of message frames. Each output byte carries start-of-frame and end-of-frame markers. The length of each frame comes from one of two places: a fixed frame-size value, or a per-message byte count that software may rewrite between frames. When the fixed value is used, every frame has that length except the last one, which takes whatever bytes remain.

There are two window modes, chosen by a mode bit that is sampled at start:

- **Stop-and-go mode.** The segmenter stops after each frame and raises an end-of-message flag. It continues only after an enable pulse.
- **Continuous mode.** One start sends every frame of the block. An end-of-frame flag is raised after each frame, and a programmed number of idle cycles separates consecutive frames.

A window holds at most eight frames. A start that is rejected sends nothing and sets an error flag.

Top module: `mfw_tx_segmenter`

## Requirements
- R1: When `size_sel`=0, each frame length is taken from `frm_size`. When `size_sel`=1, it is taken from `msg_cnt`, which is sampled again at the start of every frame.
- R2: Every frame except the final one has exactly the selected length. The final frame carries the remaining bytes. `out_sof` is set on the first byte of each frame and `out_eof` on its last byte.
- R3: In stop-and-go mode (`brick_mode`=0 at start):
  - each frame's last byte sets `irq_eom` in the same cycle as `out_eof`;
  - `in_ready` then stays low until an `enable` pulse;
  - after the final frame the block returns to idle.
- R4: In continuous mode (`brick_mode`=1 at start):
  - a single `start` sends all frames with no enable pulse;
  - each frame's last byte sets `irq_eof` in the same cycle as `out_eof`.
- R5: In continuous mode, while input stays valid, exactly `gap_cnt` (sampled at start) cycles with `out_valid` low separate one frame's `out_eof` byte from the next frame's `out_sof` byte. A value of 0 gives back-to-back frames.
- R6: A start with `blk_len` > 8 × selected size sends no byte and sets `err`. A frame that would be the ninth, or would have size 0, ends the window with `err` set. An accepted start clears `err`.
- R7: A start with a selected size of 0 or a `blk_len` of 0 sends no byte and sets `err`.
- R8: `irq_eom` and `irq_eof` are sticky. A high `clr_eom`/`clr_eof` clears the flag on the next edge. A set in the same cycle as a clear wins.
- R9: In the middle of a frame, a cycle with `in_valid` low accepts nothing and emits nothing, and the frame's byte count does not advance. Frames are never split by input gaps.
- R10: Synchronous active-low reset returns the block to idle, drops `in_ready` and every output marker, and clears `err` and both flags.
- R11: A byte accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid` high during the following cycle. A `start` that arrives while a window is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a window (ignored when not idle) |
| enable | input | 1 | Resume after a frame in stop-and-go mode |
| blk_len | input | 16 | Total bytes in the transfer block |
| frm_size | input | 12 | Fixed frame size |
| msg_cnt | input | 12 | Per-message byte count |
| size_sel | input | 1 | 0: use `frm_size`, 1: use `msg_cnt` |
| brick_mode | input | 1 | 1: continuous mode, 0: stop-and-go mode |
| gap_cnt | input | 8 | Idle cycles between frames in continuous mode |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Segmenter takes a byte this cycle |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| clr_eom | input | 1 | Clear `irq_eom` |
| clr_eof | input | 1 | Clear `irq_eof` |
| irq_eom | output | 1 | Sticky end-of-message flag |
| irq_eof | output | 1 | Sticky end-of-frame flag |
| err | output | 1 | Rejected start or aborted window |

## Verification
All results appear with a fixed latency:

- An output byte and its markers appear in the cycle after the edge that accepted it.
- A flag set by a frame's last byte rises in that same cycle, beside `out_eof`.
- A rejected start shows `err` and a resume shows `in_ready` one edge later.
- A gap of N cycles puts the next start-of-frame byte N+1 cycles after the end-of-frame byte.

The bench's behavioural model advances on the same clock edges, and every port is compared at the falling edge, so each value is taken in the cycle it is due. Inputs change just after the falling edge. Separate checks measure the frame lengths and the gaps as seen at the output.

// File: rtl/mfw_pkg.sv
// Package: shared state encoding for the multi-frame window segmenter.
package mfw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for start
        ST_SEND = 2'd1,   // passing bytes of the current frame
        ST_WAIT = 2'd2,   // stop-and-go: waiting for enable
        ST_GAP  = 2'd3    // continuous: inter-frame idle time
    } seg_state_t;
endpackage

// File: rtl/mfw_len_calc.sv
// mfw_len_calc: combinational frame length and window check.
// Gives min(size, avail) as the next frame length.
// Flags a window that is empty, has a zero size, or needs more than
// MAX_FRAMES frames. Assumes avail fits LEN_W bits.
module mfw_len_calc #(
    parameter int LEN_W      = 16,
    parameter int SIZE_W     = 12,
    parameter int MAX_FRAMES = 8
) (
    input  logic [SIZE_W-1:0] size,
    input  logic [LEN_W-1:0]  avail,
    output logic [LEN_W-1:0]  len,
    output logic              zero_size,
    output logic              bad_window
);
    localparam int WIDE_W = LEN_W + SIZE_W + 1;
    logic [WIDE_W-1:0] cap;
    logic [LEN_W-1:0]  size_x;

    // Purpose: length selection and window-capacity check.
    always_comb begin
        size_x     = LEN_W'(size);
        cap        = WIDE_W'(size) * WIDE_W'(MAX_FRAMES);
        len        = (size_x < avail) ? size_x : avail;
        zero_size  = (size == '0);
        bad_window = zero_size || (avail == '0) || (WIDE_W'(avail) > cap);
    end
endmodule

// File: rtl/mfw_gap_timer.sv
// mfw_gap_timer: counts the idle cycles between frames in continuous mode.
// The load value must be nonzero. done is high in the last idle cycle.
module mfw_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [GAP_W-1:0] cnt;

    // Purpose: load on frame end, count down while the gap runs.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (run && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = run && (cnt == GAP_W'(1));

    p_gap_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0));
endmodule

// File: rtl/mfw_sticky_flag.sv
// mfw_sticky_flag: set-dominant sticky flag with write-one-to-clear.
module mfw_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Purpose: hold the flag; a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
endmodule

// File: rtl/mfw_tx_segmenter.sv
// mfw_tx_segmenter: cuts one transfer block into a window of up to
// MAX_FRAMES frames. The window runs in stop-and-go or continuous mode.
// Assumes the downstream transmitter takes a byte every cycle out_valid is
// high. The mode and gap are sampled at start. The size source is read
// afresh at the start of every frame.
module mfw_tx_segmenter #(
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 16,
    parameter int SIZE_W     = 12,
    parameter int GAP_W      = 8,
    parameter int MAX_FRAMES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              enable,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic [SIZE_W-1:0] frm_size,
    input  logic [SIZE_W-1:0] msg_cnt,
    input  logic              size_sel,
    input  logic              brick_mode,
    input  logic [GAP_W-1:0]  gap_cnt,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    input  logic              clr_eom,
    input  logic              clr_eof,
    output logic              irq_eom,
    output logic              irq_eof,
    output logic              err
);
    import mfw_pkg::*;

    localparam int IDX_W = $clog2(MAX_FRAMES + 1);
    localparam int N_IRQ = 2;

    seg_state_t        st;
    logic [LEN_W-1:0]  remain, flen, avail, nxt_len;
    logic [IDX_W-1:0]  frm_idx;
    logic              first, brick_q;
    logic [GAP_W-1:0]  gap_q;
    logic [SIZE_W-1:0] cur_size;
    logic              zero_size, bad_window;
    logic              last_byte, more_left, gap_done, gap_load;
    logic              new_frame, abort;
    logic [N_IRQ-1:0]  irq_set, irq_clr, irq_q;

    // Purpose: pick the size source and the bytes still available.
    always_comb begin
        cur_size  = size_sel ? msg_cnt : frm_size;
        last_byte = (st == ST_SEND) && in_valid && (flen == LEN_W'(1));
        more_left = remain != LEN_W'(1);
        if (st == ST_IDLE)  avail = blk_len;
        else if (last_byte) avail = remain - 1'b1;
        else                avail = remain;
    end

    mfw_len_calc #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .MAX_FRAMES(MAX_FRAMES)) u_len (
        .size(cur_size), .avail(avail), .len(nxt_len),
        .zero_size(zero_size), .bad_window(bad_window)
    );

    // Purpose: decide when a following frame of the window begins.
    always_comb begin
        gap_load  = last_byte && more_left && brick_q && (gap_q != '0);
        new_frame = (last_byte && more_left && brick_q && (gap_q == '0))
                 || ((st == ST_WAIT) && enable)
                 || gap_done;
        abort     = new_frame && (zero_size || frm_idx == IDX_W'(MAX_FRAMES));
    end

    mfw_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_q),
        .run(st == ST_GAP), .done(gap_done)
    );

    // Purpose: window sequencing, byte counting and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;  remain <= '0;  flen <= '0;  frm_idx <= '0;
            first <= 1'b0;  brick_q <= 1'b0;  gap_q <= '0;  err <= 1'b0;
            out_valid <= 1'b0;  out_sof <= 1'b0;  out_eof <= 1'b0;
            out_data <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    if (bad_window) begin
                        err <= 1'b1;
                    end else begin
                        err     <= 1'b0;
                        remain  <= blk_len;
                        flen    <= nxt_len;
                        first   <= 1'b1;
                        frm_idx <= IDX_W'(1);
                        brick_q <= brick_mode;
                        gap_q   <= gap_cnt;
                        st      <= ST_SEND;
                    end
                end
                ST_SEND: if (in_valid) begin
                    out_valid <= 1'b1;
                    out_data  <= in_data;
                    out_sof   <= first;
                    out_eof   <= last_byte;
                    first     <= 1'b0;
                    flen      <= flen - 1'b1;
                    remain    <= remain - 1'b1;
                    if (last_byte) begin
                        if (!more_left)   st <= ST_IDLE;
                        else if (!brick_q) st <= ST_WAIT;
                        else if (gap_q != '0) st <= ST_GAP;
                    end
                end
                default: ;
            endcase
            if (new_frame) begin
                if (abort) begin
                    err <= 1'b1;
                    st  <= ST_IDLE;
                end else begin
                    flen    <= nxt_len;
                    first   <= 1'b1;
                    frm_idx <= frm_idx + 1'b1;
                    st      <= ST_SEND;
                end
            end
        end
    end

    assign in_ready   = (st == ST_SEND);
    assign irq_set[0] = last_byte && !brick_q;
    assign irq_set[1] = last_byte && brick_q;
    assign irq_clr    = {clr_eof, clr_eom};

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        mfw_sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(irq_set[i]), .clr(irq_clr[i]), .q(irq_q[i])
        );
    end

    assign irq_eom = irq_q[0];
    assign irq_eof = irq_q[1];

    p_eom_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && !brick_q) |-> irq_eom);
    p_eof_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && brick_q) |-> irq_eof);
    p_gap_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && brick_q && gap_q != '0 && st == ST_GAP) |=> !out_valid);
    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start && bad_window) |=> (err && !in_ready));
    p_frame_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_idx <= IDX_W'(MAX_FRAMES));
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND && !in_valid) |=> ($stable(flen) && !out_valid));
endmodule

// File: tb/mfw_tx_segmenter_tb.sv
// Bench: behavioural per-cycle model of the segmenter, compared on every
// falling edge. Frame lengths and gaps are also measured at the output.
module mfw_tx_segmenter_tb;
    logic clk = 0, rst_n = 0, start = 0, enable = 0;
    logic [15:0] blk_len = 0;
    logic [11:0] frm_size = 0, msg_cnt = 0;
    logic size_sel = 0, brick_mode = 0, clr_eom = 0, clr_eof = 0;
    logic [7:0] gap_cnt = 0, dcnt = 0;
    logic in_valid, in_ready, out_valid, out_sof, out_eof, irq_eom, irq_eof, err;
    logic [7:0] out_data;
    int cyc = 0, checks = 0, errors = 0, vmode = 0;
    bit checking = 0;

    always #2.5 clk = ~clk;

    assign in_valid = (vmode == 0) ? 1'b1 : ((cyc % 3) != 1);

    mfw_tx_segmenter u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .blk_len(blk_len),
        .frm_size(frm_size), .msg_cnt(msg_cnt), .size_sel(size_sel),
        .brick_mode(brick_mode), .gap_cnt(gap_cnt), .in_data(dcnt),
        .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .clr_eom(clr_eom), .clr_eof(clr_eof), .irq_eom(irq_eom),
        .irq_eof(irq_eof), .err(err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (in_valid && in_ready) dcnt <= dcnt + 1'b1;
    end

    // Reference model: phase 0 idle, 1 sending, 2 awaiting enable, 3 gap.
    int ph = 0, rem = 0, fl = 0, gleft = 0, nfr = 0, gp = 0;
    bit first = 0, bw = 0;
    bit e_valid = 0, e_sof = 0, e_eof = 0, e_eom = 0, e_eof_irq = 0, e_err = 0;
    logic [7:0] e_data = 0;

    function automatic int mn(int a, int b);
        return (a < b) ? a : b;
    endfunction

    always @(posedge clk) begin
        int sz;
        bit s_eom, s_eof, nf;
        if (!rst_n) begin
            ph = 0; rem = 0; fl = 0; first = 0; bw = 0;
            e_valid = 0; e_sof = 0; e_eof = 0; e_eom = 0; e_eof_irq = 0; e_err = 0;
        end else begin
            sz = size_sel ? int'(msg_cnt) : int'(frm_size);
            e_valid = 0; e_sof = 0; e_eof = 0; s_eom = 0; s_eof = 0; nf = 0;
            case (ph)
                0: if (start) begin
                    if (blk_len == 0 || sz == 0 || int'(blk_len) > 8 * sz) e_err = 1;
                    else begin
                        e_err = 0; rem = blk_len; fl = mn(sz, rem); first = 1;
                        nfr = 1; bw = brick_mode; gp = gap_cnt; ph = 1;
                    end
                end
                1: if (in_valid) begin
                    e_valid = 1; e_data = dcnt; e_sof = first; first = 0;
                    e_eof = (fl == 1); fl--; rem--;
                    if (fl == 0) begin
                        if (bw) s_eof = 1; else s_eom = 1;
                        if (rem == 0) ph = 0;
                        else if (!bw) ph = 2;
                        else if (gp == 0) nf = 1;
                        else begin gleft = gp; ph = 3; end
                    end
                end
                2: if (enable) nf = 1;
                default: if (gleft == 1) nf = 1; else gleft--;
            endcase
            if (nf) begin
                if (sz == 0 || nfr == 8) begin e_err = 1; ph = 0; end
                else begin fl = mn(sz, rem); first = 1; nfr++; ph = 1; end
            end
            e_eom = s_eom ? 1'b1 : (clr_eom ? 1'b0 : e_eom);
            e_eof_irq = s_eof ? 1'b1 : (clr_eof ? 1'b0 : e_eof_irq);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Output scoreboard: frame lengths and idle gap between frames.
    int got_len[$];
    int run_len = 0, idle = 0, last_gap = -1;
    bit seen_eof = 0;

    always @(negedge clk) if (checking) begin
        chk("R11", "out_valid", out_valid, e_valid);
        if (e_valid) chk("R11", "out_data", out_data, e_data);
        chk("R2", "out_sof", out_sof, e_sof);
        chk("R2", "out_eof", out_eof, e_eof);
        chk("R9", "in_ready", in_ready, ph == 1);
        chk("R3 R8", "irq_eom", irq_eom, e_eom);
        chk("R4 R8", "irq_eof", irq_eof, e_eof_irq);
        chk("R6", "err", err, e_err);
        if (out_valid) begin
            if (out_sof && seen_eof) last_gap = idle;
            run_len++;
            if (out_eof) begin got_len.push_back(run_len); run_len = 0; idle = 0; seen_eof = 1; end
        end else idle++;
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic go();
        got_len.delete(); run_len = 0; seen_eof = 0; last_gap = -1;
        start = 1; tick(); start = 0; tick();
        while (ph != 0) begin
            if (ph == 2) begin enable = 1; tick(); enable = 0; end
            else tick();
        end
        repeat (3) tick();
    endtask

    task automatic chk_frames(string req, int e[$]);
        chk(req, "frame count", got_len.size(), e.size());
        foreach (e[i]) if (i < got_len.size()) chk(req, "frame length", got_len[i], e[i]);
    endtask

    initial begin
        repeat (2) tick();
        checking = 1;
        chk("R10", "out_valid in reset", out_valid, 0);
        chk("R10", "in_ready in reset", in_ready, 0);
        rst_n = 1; tick();

        // R2 R3: stop-and-go, fixed size 4, block 10 -> 4,4,2
        blk_len = 10; frm_size = 4; size_sel = 0; brick_mode = 0; go();
        chk_frames("R2", '{4, 4, 2});
        chk("R3", "irq_eom after window", irq_eom, 1);
        clr_eom = 1; tick(); clr_eom = 0; tick();
        chk("R8", "irq_eom cleared", irq_eom, 0);

        // R4 R5: continuous, size 3, block 9, gap 2
        blk_len = 9; frm_size = 3; brick_mode = 1; gap_cnt = 2; go();
        chk_frames("R4", '{3, 3, 3});
        chk("R5", "gap cycles", last_gap, 2);
        clr_eof = 1; tick(); clr_eof = 0;

        // R1: per-message count 5 overrides frm_size 2; gap 0
        blk_len = 12; frm_size = 2; msg_cnt = 5; size_sel = 1; gap_cnt = 0; go();
        chk_frames("R1", '{5, 5, 2});
        chk("R5", "back-to-back gap", last_gap, 0);

        // R1: per-message count changes between stop-and-go frames
        blk_len = 9; msg_cnt = 3; brick_mode = 0;
        got_len.delete(); run_len = 0;
        start = 1; tick(); start = 0;
        while (ph != 2) tick();
        msg_cnt = 6; enable = 1; tick(); enable = 0;
        while (ph != 0) tick();
        repeat (3) tick();
        chk_frames("R1", '{3, 6});

        // R6: more than eight frames rejected, exactly eight accepted
        size_sel = 0; frm_size = 4; blk_len = 33; brick_mode = 1; go();
        chk("R6", "err on 33/4", err, 1);
        chk("R6", "no bytes sent", got_len.size(), 0);
        blk_len = 32; go();
        chk("R6", "err cleared", err, 0);
        chk_frames("R6", '{4, 4, 4, 4, 4, 4, 4, 4});

        // R6: shrinking message count makes a ninth frame -> abort
        size_sel = 1; msg_cnt = 4; blk_len = 32; brick_mode = 0;
        got_len.delete(); run_len = 0;
        start = 1; tick(); start = 0;
        while (ph != 2) tick();
        msg_cnt = 3;
        while (ph != 0) begin
            if (ph == 2) begin enable = 1; tick(); enable = 0; end else tick();
        end
        repeat (3) tick();
        chk("R6", "ninth frame aborts", err, 1);
        chk("R6", "frames before abort", got_len.size(), 8);

        // R7: zero size or zero length
        size_sel = 0; frm_size = 0; blk_len = 8; go();
        chk("R7", "err on zero size", err, 1);
        chk("R7", "no bytes on zero size", got_len.size(), 0);
        frm_size = 4; blk_len = 0; go();
        chk("R7", "err on zero length", err, 1);

        // R9: gappy input in continuous mode, frames stay whole
        blk_len = 6; frm_size = 3; brick_mode = 1; gap_cnt = 1; vmode = 1; go();
        chk_frames("R9", '{3, 3});
        vmode = 0;

        // R10: reset in the middle of a frame
        blk_len = 20; frm_size = 10;
        start = 1; tick(); start = 0; repeat (4) tick();
        rst_n = 0; tick(); tick();
        chk("R10", "out_valid after reset", out_valid, 0);
        chk("R10", "in_ready after reset", in_ready, 0);
        chk("R10", "flags after reset", irq_eom | irq_eof | err, 0);
        rst_n = 1; repeat (3) tick();

        checking = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) if (cyc > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule